// File: doc/BRIEF.md
# Debug Halt Control Sequencer

This block decides when a processor core enters and leaves its debug halted state. After the system reset is released it counts a fixed delay before it signals the start of reset exception processing. A breakpoint request that arrives early in that delay holds the core in a reset halt instead. The debug side can then latch emulation mode. A later go command either jumps to a program counter written while halted or lets reset processing continue.

Outside that early window, a breakpoint request is a pending pseudo-interrupt. It is acted on only at the next instruction-boundary sample strobe, and there it competes with a hardware trigger and a halt instruction. The highest-priority source is reported in a 4-bit field. A stop-instruction indication parks the core in a stopped state, and a breakpoint request moves it from there into the halted state. A go command then resumes at the instruction after the stop.

The FSM has five states. RST_WAIT counts after reset. RST_HALT is the reset halt. RUN is normal execution. STOPPED follows a stop instruction. HALT is the runtime halt. The transitions are:

| Transition | Condition |
|---|---|
| RST_WAIT to RST_HALT | breakpoint inside the window |
| RST_WAIT to RUN | delay expired |
| RST_HALT to RUN | go |
| RUN to HALT | sample strobe with any source |
| RUN to STOPPED | stop indication |
| STOPPED to HALT | breakpoint |
| HALT to RUN | go |

Top module: `dbg_halt_seq`

## Requirements
- R1: After reset is released, `rst_proc_start` is high for exactly one cycle. That cycle immediately follows the 16th rising clock edge after the release, provided no breakpoint was seen in the window. A breakpoint request later in the delay does not move this pulse.
- R2: If `bkpt_req` is high at any of the first 8 rising edges after reset release, the block is halted after that edge. In that case `pst` = 0xF, `halt_src` = 1, and no `rst_proc_start` pulse follows.
- R3: `halted` is 1 and `pst` = 0xF in both halted states. `pst` = 0xE while stopped, and `pst` = 0x0 in every other state.
- R4: `emu_mode` is set by `emu_req` only while in the reset halt. Requests in any other state leave it unchanged. It stays set until the next reset.
- R5: A `bkpt_req` outside the reset window does not halt the core by itself. The request is held, and the core halts after the next edge at which `insn_sample` is high while running.
- R6: `stop_ind` while running moves the block to STOPPED. `insn_sample` is ignored there. `bkpt_req` while stopped halts the block with `halt_src` = 1.
- R7: `go_cmd` in the reset halt leaves the halted state. If `pc_loaded` is 1, `resume_pc` pulses for one cycle. Otherwise `rst_proc_start` pulses for one cycle.
- R8: `go_cmd` in the runtime halt returns to RUN at the next instruction. It raises neither pulse and clears `halt_src` to 0.
- R9: `halt_src` encoding: 0 none, 1 breakpoint, 2 hardware trigger, 3 halt instruction. When several sources coincide at a sample, the priority is trigger, then breakpoint, then halt instruction.
- R10: The pending breakpoint flag is cleared when a halt is taken at a sample, and by reset. A pending request carries over from the reset delay into RUN.
- R11: While reset is asserted, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | System reset, active low, asynchronous |
| bkpt_req | input | 1 | Breakpoint request |
| hw_trig | input | 1 | Hardware trigger halt request |
| halt_insn | input | 1 | Halt instruction executed |
| insn_sample | input | 1 | Instruction-boundary sample strobe |
| stop_ind | input | 1 | Stop instruction executed |
| go_cmd | input | 1 | Debug go command |
| pc_loaded | input | 1 | Program counter was written while halted |
| emu_req | input | 1 | Request to latch emulation mode |
| halted | output | 1 | Core is in a halted state |
| pst | output | 4 | Processor status code |
| halt_src | output | 4 | Halt source of the current halt |
| emu_mode | output | 1 | Emulation mode latch |
| rst_proc_start | output | 1 | Start reset exception processing pulse |
| resume_pc | output | 1 | Resume at loaded PC pulse |

## Verification
Every state change and every output is registered, so a strobe driven before edge N shows its effect right after edge N. The only exception is the reset start pulse, which comes 16 edges after release, and the reset halt, which follows the window edge that saw the breakpoint. The driver records each expectation together with the cycle count at which it is due. The monitor compares outputs shortly after each falling edge and checks only the items whose due cycle has arrived. As a result, both the absence of an early halt and the presence of the late pulse are checked at fixed, computed cycles.

// File: rtl/dbg_halt_pkg.sv
package dbg_halt_pkg;
    typedef enum logic [2:0] {
        ST_RWAIT = 3'd0,
        ST_RHALT = 3'd1,
        ST_RUN   = 3'd2,
        ST_STOP  = 3'd3,
        ST_HALT  = 3'd4
    } dh_state_e;

    typedef enum logic [3:0] {
        SRC_NONE = 4'd0,
        SRC_BKPT = 4'd1,
        SRC_TRIG = 4'd2,
        SRC_INSN = 4'd3
    } halt_src_e;

    localparam logic [3:0] PST_RUN  = 4'h0;
    localparam logic [3:0] PST_STOP = 4'hE;
    localparam logic [3:0] PST_HALT = 4'hF;
endpackage

// File: rtl/dbg_rst_timer.sv
module dbg_rst_timer #(
    parameter int WAIT_CYC = 16,
    parameter int WIN_CYC  = 8
) (
    input  logic clk,
    input  logic rst_n,
    output logic in_win,
    output logic expire
);
    localparam int CW = $clog2(WAIT_CYC + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(WAIT_CYC - 1);
    localparam logic [CW-1:0] CNT_SAT  = CW'(WAIT_CYC);
    localparam logic [CW-1:0] CNT_WIN  = CW'(WIN_CYC);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               cnt_q <= '0;
        else if (cnt_q != CNT_SAT) cnt_q <= cnt_q + 1'b1;
    end

    assign in_win = (cnt_q < CNT_WIN);
    assign expire = (cnt_q == CNT_LAST);

    // R1
    cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_SAT) |=> (cnt_q == CNT_SAT));
endmodule

// File: rtl/dbg_bkpt_pend.sv
module dbg_bkpt_pend (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic pend_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     pend_o <= 1'b0;
        else if (clr_i) pend_o <= 1'b0;
        else if (set_i) pend_o <= 1'b1;
    end
endmodule

// File: rtl/dbg_halt_prio.sv
module dbg_halt_prio
    import dbg_halt_pkg::*;
(
    input  logic      trig_i,
    input  logic      bkpt_i,
    input  logic      insn_i,
    output halt_src_e src_o,
    output logic      any_o
);
    always_comb begin
        if (trig_i)      src_o = SRC_TRIG;
        else if (bkpt_i) src_o = SRC_BKPT;
        else if (insn_i) src_o = SRC_INSN;
        else             src_o = SRC_NONE;
    end
    assign any_o = trig_i | bkpt_i | insn_i;
endmodule

// File: rtl/dbg_halt_seq.sv
module dbg_halt_seq
    import dbg_halt_pkg::*;
#(
    parameter int WAIT_CYC = 16,
    parameter int WIN_CYC  = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bkpt_req,
    input  logic       hw_trig,
    input  logic       halt_insn,
    input  logic       insn_sample,
    input  logic       stop_ind,
    input  logic       go_cmd,
    input  logic       pc_loaded,
    input  logic       emu_req,
    output logic       halted,
    output logic [3:0] pst,
    output logic [3:0] halt_src,
    output logic       emu_mode,
    output logic       rst_proc_start,
    output logic       resume_pc
);
    dh_state_e state_q, state_d;
    halt_src_e src_q, prio_src;
    logic      win, expire, pend_q, prio_any;
    logic      start_rst, start_pc, pend_set, pend_clr;

    dbg_rst_timer #(.WAIT_CYC(WAIT_CYC), .WIN_CYC(WIN_CYC)) timer_i (
        .clk(clk), .rst_n(rst_n), .in_win(win), .expire(expire)
    );

    assign pend_set = bkpt_req && ((state_q == ST_RUN) || (state_q == ST_RWAIT && !win));
    assign pend_clr = (state_q == ST_RUN) && insn_sample && prio_any;

    dbg_bkpt_pend pend_i (
        .clk(clk), .rst_n(rst_n), .set_i(pend_set), .clr_i(pend_clr), .pend_o(pend_q)
    );

    dbg_halt_prio prio_i (
        .trig_i(hw_trig), .bkpt_i(pend_q | bkpt_req), .insn_i(halt_insn),
        .src_o(prio_src), .any_o(prio_any)
    );

    // next-state logic
    always_comb begin
        state_d   = state_q;
        start_rst = 1'b0;
        start_pc  = 1'b0;
        unique case (state_q)
            ST_RWAIT: begin
                if (bkpt_req && win) state_d = ST_RHALT;
                else if (expire) begin
                    state_d   = ST_RUN;
                    start_rst = 1'b1;
                end
            end
            ST_RHALT: begin
                if (go_cmd) begin
                    state_d   = ST_RUN;
                    start_pc  = pc_loaded;
                    start_rst = !pc_loaded;
                end
            end
            ST_RUN: begin
                if (insn_sample && prio_any) state_d = ST_HALT;
                else if (stop_ind)           state_d = ST_STOP;
            end
            ST_STOP: begin
                if (bkpt_req) state_d = ST_HALT;
            end
            ST_HALT: begin
                if (go_cmd) state_d = ST_RUN;
            end
            default: state_d = ST_RWAIT;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RWAIT;
        else        state_q <= state_d;
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q          <= SRC_NONE;
            emu_mode       <= 1'b0;
            rst_proc_start <= 1'b0;
            resume_pc      <= 1'b0;
        end else begin
            rst_proc_start <= start_rst;
            resume_pc      <= start_pc;
            if (state_q == ST_RHALT && emu_req) emu_mode <= 1'b1;
            if (state_d == ST_RUN)
                src_q <= SRC_NONE;
            else if (state_q == ST_RUN && state_d == ST_HALT)
                src_q <= prio_src;
            else if ((state_q == ST_RWAIT && state_d == ST_RHALT) ||
                     (state_q == ST_STOP && state_d == ST_HALT))
                src_q <= SRC_BKPT;
        end
    end

    always_comb begin
        halted = (state_q == ST_RHALT) || (state_q == ST_HALT);
        if (halted)                  pst = PST_HALT;
        else if (state_q == ST_STOP) pst = PST_STOP;
        else                         pst = PST_RUN;
    end
    assign halt_src = src_q;

    // R2
    win_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RWAIT && bkpt_req && win) |=> (halted && !rst_proc_start));
    // R4
    emu_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(emu_mode) |-> ($past(state_q) == ST_RHALT));
    // R7
    pc_resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resume_pc |-> $past(go_cmd && pc_loaded));
    // R7
    pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(resume_pc && rst_proc_start));
    // R9
    src_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> (halt_src != 4'd0));
    // R5
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && state_q == ST_RUN && !insn_sample) |=> pend_q);
endmodule

// File: tb/dbg_halt_seq_tb_top.sv
module dbg_halt_seq_tb_top;
    logic clk = 1'b0;
    logic rst_n, bkpt_req, hw_trig, halt_insn, insn_sample, stop_ind, go_cmd, pc_loaded, emu_req;
    logic halted, emu_mode, rst_proc_start, resume_pc;
    logic [3:0] pst, halt_src;

    always #2 clk = ~clk;

    dbg_halt_seq dut_i (
        .clk(clk), .rst_n(rst_n), .bkpt_req(bkpt_req), .hw_trig(hw_trig),
        .halt_insn(halt_insn), .insn_sample(insn_sample), .stop_ind(stop_ind),
        .go_cmd(go_cmd), .pc_loaded(pc_loaded), .emu_req(emu_req),
        .halted(halted), .pst(pst), .halt_src(halt_src), .emu_mode(emu_mode),
        .rst_proc_start(rst_proc_start), .resume_pc(resume_pc)
    );

    typedef struct {
        int         due;
        logic       h;
        logic [3:0] p;
        logic [3:0] s;
        logic       e;
        logic       rs;
        logic       rp;
        string      req;
    } exp_t;

    exp_t q[$];
    int cyc = 0, total = 0, bad = 0;
    bit done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic expect_at(int d, logic h, logic [3:0] p, logic [3:0] s,
                             logic e, logic rs, logic rp, string req);
        exp_t it;
        it.due = cyc + d; it.h = h; it.p = p; it.s = s;
        it.e = e; it.rs = rs; it.rp = rp; it.req = req;
        q.push_back(it);
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_go(logic pc);
        go_cmd = 1'b1; pc_loaded = pc;
        tick(1);
        go_cmd = 1'b0; pc_loaded = 1'b0;
        tick(1);
    endtask

    // monitor: compare due items just after each falling edge
    always begin
        @(negedge clk);
        #1;
        for (int i = q.size() - 1; i >= 0; i--) begin
            if (q[i].due == cyc) begin
                total++;
                if (halted !== q[i].h || pst !== q[i].p || halt_src !== q[i].s ||
                    emu_mode !== q[i].e || rst_proc_start !== q[i].rs || resume_pc !== q[i].rp) begin
                    bad++;
                    $display("FAIL %s cyc=%0d actual h=%b pst=%h src=%h emu=%b rs=%b rp=%b expected h=%b pst=%h src=%h emu=%b rs=%b rp=%b",
                        q[i].req, cyc, halted, pst, halt_src, emu_mode, rst_proc_start, resume_pc,
                        q[i].h, q[i].p, q[i].s, q[i].e, q[i].rs, q[i].rp);
                end
                q.delete(i);
            end
        end
    end

    initial begin
        #200000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 0; bkpt_req = 0; hw_trig = 0; halt_insn = 0; insn_sample = 0;
        stop_ind = 0; go_cmd = 0; pc_loaded = 0; emu_req = 0;
        tick(3);
        expect_at(0, 0, 4'h0, 0, 0, 0, 0, "R11");
        tick(1);
        // R1: plain release
        rst_n = 1;
        expect_at(15, 0, 4'h0, 0, 0, 0, 0, "R1");
        expect_at(16, 0, 4'h0, 0, 0, 1, 0, "R1");
        expect_at(17, 0, 4'h0, 0, 0, 0, 0, "R1");
        tick(20);
        // R5: pending breakpoint waits for a sample
        bkpt_req = 1; tick(1); bkpt_req = 0;
        expect_at(0, 0, 4'h0, 0, 0, 0, 0, "R5");
        tick(3);
        expect_at(0, 0, 4'h0, 0, 0, 0, 0, "R5");
        insn_sample = 1;
        expect_at(1, 1, 4'hF, 1, 0, 0, 0, "R5");
        tick(1); insn_sample = 0; tick(1);
        // R4: emulation request ignored in runtime halt
        emu_req = 1;
        expect_at(1, 1, 4'hF, 1, 0, 0, 0, "R4");
        tick(1); emu_req = 0; tick(1);
        // R8: go from runtime halt
        go_cmd = 1;
        expect_at(1, 0, 4'h0, 0, 0, 0, 0, "R8");
        tick(1); go_cmd = 0; tick(1);
        // R10: pending was consumed
        insn_sample = 1;
        expect_at(1, 0, 4'h0, 0, 0, 0, 0, "R10");
        tick(1); insn_sample = 0; tick(1);
        // R9: priority
        hw_trig = 1; halt_insn = 1; bkpt_req = 1; insn_sample = 1;
        expect_at(1, 1, 4'hF, 2, 0, 0, 0, "R9");
        tick(1); hw_trig = 0; halt_insn = 0; bkpt_req = 0; insn_sample = 0; tick(1);
        do_go(0);
        halt_insn = 1; bkpt_req = 1; insn_sample = 1;
        expect_at(1, 1, 4'hF, 1, 0, 0, 0, "R9");
        tick(1); halt_insn = 0; bkpt_req = 0; insn_sample = 0; tick(1);
        do_go(0);
        halt_insn = 1; insn_sample = 1;
        expect_at(1, 1, 4'hF, 3, 0, 0, 0, "R9");
        tick(1); halt_insn = 0; insn_sample = 0; tick(1);
        go_cmd = 1;
        expect_at(1, 0, 4'h0, 0, 0, 0, 0, "R8");
        tick(1); go_cmd = 0; tick(1);
        // R6: stop then breakpoint
        stop_ind = 1;
        expect_at(1, 0, 4'hE, 0, 0, 0, 0, "R3");
        tick(1); stop_ind = 0;
        insn_sample = 1; halt_insn = 1;
        expect_at(1, 0, 4'hE, 0, 0, 0, 0, "R6");
        tick(1); insn_sample = 0; halt_insn = 0; tick(1);
        bkpt_req = 1;
        expect_at(1, 1, 4'hF, 1, 0, 0, 0, "R6");
        tick(1); bkpt_req = 0; tick(1);
        go_cmd = 1;
        expect_at(1, 0, 4'h0, 0, 0, 0, 0, "R8");
        tick(1); go_cmd = 0; tick(1);
        // R2 + R7: reset halt, emulation, resume at PC
        rst_n = 0; tick(2);
        rst_n = 1; bkpt_req = 1;
        expect_at(1, 1, 4'hF, 1, 0, 0, 0, "R2");
        tick(1); bkpt_req = 0;
        expect_at(15, 1, 4'hF, 1, 0, 0, 0, "R2");
        tick(17);
        emu_req = 1;
        expect_at(1, 1, 4'hF, 1, 1, 0, 0, "R4");
        tick(1); emu_req = 0; tick(1);
        go_cmd = 1; pc_loaded = 1;
        expect_at(1, 0, 4'h0, 0, 1, 0, 1, "R7");
        expect_at(2, 0, 4'h0, 0, 1, 0, 0, "R7");
        tick(1); go_cmd = 0; pc_loaded = 0; tick(3);
        // R2 window edge: 8th edge, then go without PC
        rst_n = 0; tick(2);
        expect_at(0, 0, 4'h0, 0, 0, 0, 0, "R4");
        rst_n = 1; tick(7);
        bkpt_req = 1;
        expect_at(1, 1, 4'hF, 1, 0, 0, 0, "R2");
        tick(1); bkpt_req = 0; tick(1);
        go_cmd = 1;
        expect_at(1, 0, 4'h0, 0, 0, 1, 0, "R7");
        tick(1); go_cmd = 0; tick(2);
        emu_req = 1;
        expect_at(1, 0, 4'h0, 0, 0, 0, 0, "R4");
        tick(1); emu_req = 0; tick(1);
        // 9th edge: outside window, pending carries into RUN
        rst_n = 0; tick(2);
        rst_n = 1; tick(8);
        bkpt_req = 1;
        expect_at(1, 0, 4'h0, 0, 0, 0, 0, "R5");
        expect_at(8, 0, 4'h0, 0, 0, 1, 0, "R1");
        tick(1); bkpt_req = 0; tick(10);
        insn_sample = 1;
        expect_at(1, 1, 4'hF, 1, 0, 0, 0, "R10");
        tick(1); insn_sample = 0; tick(1);
        do_go(0);
        tick(4);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule